// File: doc/BRIEF.md
# Dual-Clock Jitter Random Bit Collector

This block turns the phase wander between two unrelated oscillators into a stream of random bits. It runs entirely on a fast clock. It samples a slow, asynchronous reference clock, optionally divides it, and measures how many fast cycles fit into each divided reference period. Only the parity of each measurement is kept. Five such parities are reduced by majority vote to one output bit.

Every finished bit goes to a serial output with a one-cycle strobe, and it is also shifted into a parallel word. Once per finished bit the block also changes its own operating point, so that successive measurements do not settle into a fixed pattern. It steps a frequency-control word meant for the fast oscillator. It also toggles the low bit of the reference divider select whenever the two bits produced before the current one differ. An enable input pauses and resumes collection.

Top module: `jitter_bit_collector`

## Requirements
- R1: The reference input passes through two synchronizer flops. A rising edge is recognised in the fast domain when the second flop is high and a third, delayed copy is low.
- R2: The divided reference produces one tick per 2^div_sel recognised rising edges, so div_sel values 0, 1, 2 and 3 give ratios 1, 2, 4 and 8. A capture counter counts the enabled fast cycles from one tick to the next and wraps at 2^16. Bit 0 of that count is the raw sample.
- R3: The tick that follows reset, and the tick that follows any change of div_sel, produces no raw sample. It only restarts the measurement, and the divider count restarts at zero after a div_sel change.
- R4: Each output bit is 1 when at least three of five consecutive raw samples are 1, and 0 otherwise.
- R5: bit_valid is high for exactly one cycle, the cycle after the fifth raw sample is taken. From that cycle on, bit_out holds the new bit.
- R6: Each new bit is shifted into word_out at bit 0, and older bits move toward the MSB. word_valid is high together with bit_valid on every 16th bit since reset.
- R7: freq_ctrl increases by 5, modulo 256, with every output bit.
- R8: With every output bit, div_sel[0] is inverted if word_out[0] XOR word_out[1], taken before the shift, is 1. div_sel[1] never changes after reset.
- R9: While enable is low, word_out, bit_out, freq_ctrl and div_sel stay unchanged, and bit_valid and word_valid stay low. The capture counter and divider do not advance, and edges seen in that time are dropped.
- R10: While rst_n is low at a clock edge, word_out, bit_out, freq_ctrl and the strobes clear to 0, and div_sel loads its reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Collection enable |
| ref_clk_async | input | 1 | Slow reference clock, asynchronous to clk |
| bit_out | output | 1 | Most recent output bit |
| bit_valid | output | 1 | One-cycle strobe per new bit |
| word_out | output | 16 | Parallel shift register of output bits |
| word_valid | output | 1 | Strobe on every 16th bit |
| freq_ctrl | output | 8 | Fast-oscillator frequency-control word |
| div_sel | output | 2 | Reference divider select |

## Verification
The bench builds the block with the divider select reset to 1, so the XOR feedback keeps switching between ratios 2 and 1. That exercises both the discarded tick after a divider change and the plain tick without a change. Reference half-periods are random within 2 to 10 fast cycles, so both count parities and all vote mixes appear. The run is long enough for freq_ctrl to wrap past 255 and for several 16-bit words to complete. Enable is dropped for random spans, including spans that fall in the middle of a measurement.

// File: rtl/jbc_pkg.sv
// Package: shared types for the jitter bit collector.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package jbc_pkg;
    // One raw measurement result handed from capture to the voter.
    typedef struct packed {
        logic valid;
        logic lsb;
    } jbc_sample_t;
endpackage

// File: rtl/jbc_edge_divider.sv
// Synchronizes the asynchronous reference, finds its rising edges and
// divides them by 2^div_sel, issuing one tick per divided period.
// Assumes ref_async is a slow clock and restart only occurs with a tick.
module jbc_edge_divider #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_SEL_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 ref_async,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 restart,
    output logic                 tick
);
    localparam int DCNT_W = (1 << DIV_SEL_W) - 1;

    logic [SYNC_STAGES:0] sync_q;
    logic [DCNT_W-1:0]    dcnt;
    logic [DCNT_W:0]      ratio;
    logic                 rise;
    logic                 edge_ev;
    logic                 at_last;

    // Synchronizer chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_async};
    end

    assign rise    = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign edge_ev = enable & rise;
    assign ratio   = {{DCNT_W{1'b0}}, 1'b1} << div_sel;
    assign at_last = ({1'b0, dcnt} == (ratio - 1'b1));
    assign tick    = edge_ev & at_last;

    // Divider position counter, cleared on a divider change.
    always_ff @(posedge clk) begin
        if (!rst_n)       dcnt <= '0;
        else if (restart) dcnt <= '0;
        else if (edge_ev) dcnt <= at_last ? '0 : dcnt + 1'b1;
    end

    assert_edges_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_dcnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, dcnt} < ratio);
endmodule

// File: rtl/jbc_period_capture.sv
// Counts fast cycles between divided reference ticks and hands out the
// count parity as a raw sample; the first tick after reset or a restart
// only arms the measurement. Assumes tick is never high while disabled.
module jbc_period_capture
    import jbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        tick,
    input  logic        restart,
    output jbc_sample_t sample
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Period counter: the tick cycle counts as the first cycle of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (enable) cnt <= tick ? {{(CNT_W-1){1'b0}}, 1'b1} : cnt + 1'b1;
    end

    // Arm flag: a full period has been seen since reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (restart) armed <= 1'b0;
        else if (tick)    armed <= 1'b1;
    end

    assign sample.valid = tick & armed;
    assign sample.lsb   = cnt[0];

    assert_no_sample_after_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample.valid);
    assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt));
endmodule

// File: rtl/jbc_vote_feedback.sv
// Majority-votes groups of raw samples into output bits, shifts them into
// the word, and applies the per-bit feedback to the frequency-control word
// and divider select. Assumes sample.valid is never high while disabled.
module jbc_vote_feedback
    import jbc_pkg::*;
#(
    parameter int                 VOTES       = 5,
    parameter int                 WORD_W      = 16,
    parameter int                 FCW_W       = 8,
    parameter int                 FCW_STEP    = 5,
    parameter int                 DIV_SEL_W   = 2,
    parameter logic [DIV_SEL_W-1:0] DIV_SEL_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  jbc_sample_t          sample,
    output logic                 bit_out,
    output logic                 bit_valid,
    output logic [WORD_W-1:0]    word_out,
    output logic                 word_valid,
    output logic [FCW_W-1:0]     freq_ctrl,
    output logic [DIV_SEL_W-1:0] div_sel,
    output logic                 restart
);
    localparam int VCNT_W = $clog2(VOTES + 1);
    localparam int BCNT_W = $clog2(WORD_W);
    localparam logic [VCNT_W-1:0] MAJ      = VCNT_W'(VOTES / 2 + 1);
    localparam logic [VCNT_W-1:0] LAST_IDX = VCNT_W'(VOTES - 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);

    logic [VCNT_W-1:0] nvotes;
    logic [VCNT_W-1:0] ones;
    logic [VCNT_W-1:0] ones_total;
    logic [WORD_W-1:0] word_q;
    logic [BCNT_W-1:0] bits_seen;
    logic              last_vote;
    logic              new_bit;
    logic              flip;
    logic              bv_q;
    logic              wv_q;

    assign last_vote  = sample.valid & (nvotes == LAST_IDX);
    assign ones_total = ones + {{(VCNT_W-1){1'b0}}, sample.lsb};
    assign new_bit    = (ones_total >= MAJ);
    assign flip       = word_q[0] ^ word_q[1];
    assign restart    = last_vote & flip;

    // Vote accumulator over one group of raw samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nvotes <= '0;
            ones   <= '0;
        end else if (sample.valid) begin
            nvotes <= last_vote ? '0 : nvotes + 1'b1;
            ones   <= last_vote ? '0 : ones_total;
        end
    end

    // Output word, bit counter and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            bits_seen <= '0;
            bv_q      <= 1'b0;
            wv_q      <= 1'b0;
        end else begin
            bv_q <= last_vote;
            wv_q <= last_vote & (bits_seen == LAST_BIT);
            if (last_vote) begin
                word_q    <= {word_q[WORD_W-2:0], new_bit};
                bits_seen <= bits_seen + 1'b1;
            end
        end
    end

    // Feedback: step the oscillator word, toggle the divider low bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_ctrl <= '0;
            div_sel   <= DIV_SEL_RST;
        end else if (last_vote) begin
            freq_ctrl  <= freq_ctrl + FCW_W'(FCW_STEP);
            div_sel[0] <= div_sel[0] ^ flip;
        end
    end

    assign bit_out    = word_q[0];
    assign word_out   = word_q;
    assign bit_valid  = bv_q & enable;
    assign word_valid = wv_q & enable;

    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    assert_word_with_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> bit_valid);
    assert_fcw_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_vote |=> freq_ctrl == $past(freq_ctrl) + FCW_W'(FCW_STEP));
    assert_div_high_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_vote |=> div_sel[DIV_SEL_W-1:1] == $past(div_sel[DIV_SEL_W-1:1]));
    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(word_out) && $stable(freq_ctrl) && $stable(div_sel));
    assert_no_strobe_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !bit_valid && !word_valid);
endmodule

// File: rtl/jitter_bit_collector.sv
// Top level: harvests random bits from fast-cycle counts per slow reference
// period, votes them, and drives the feedback outputs. Assumes clk is much
// faster than ref_clk_async and the two are unrelated.
module jitter_bit_collector #(
    parameter int                   CNT_W       = 16,
    parameter int                   VOTES       = 5,
    parameter int                   WORD_W      = 16,
    parameter int                   FCW_W       = 8,
    parameter int                   FCW_STEP    = 5,
    parameter int                   DIV_SEL_W   = 2,
    parameter logic [DIV_SEL_W-1:0] DIV_SEL_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 ref_clk_async,
    output logic                 bit_out,
    output logic                 bit_valid,
    output logic [WORD_W-1:0]    word_out,
    output logic                 word_valid,
    output logic [FCW_W-1:0]     freq_ctrl,
    output logic [DIV_SEL_W-1:0] div_sel
);
    import jbc_pkg::*;

    logic        tick;
    logic        restart;
    jbc_sample_t sample;

    jbc_edge_divider #(
        .SYNC_STAGES (2),
        .DIV_SEL_W   (DIV_SEL_W)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ref_async (ref_clk_async),
        .div_sel   (div_sel),
        .restart   (restart),
        .tick      (tick)
    );

    jbc_period_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .restart (restart),
        .sample  (sample)
    );

    jbc_vote_feedback #(
        .VOTES       (VOTES),
        .WORD_W      (WORD_W),
        .FCW_W       (FCW_W),
        .FCW_STEP    (FCW_STEP),
        .DIV_SEL_W   (DIV_SEL_W),
        .DIV_SEL_RST (DIV_SEL_RST)
    ) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sample     (sample),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid),
        .word_out   (word_out),
        .word_valid (word_valid),
        .freq_ctrl  (freq_ctrl),
        .div_sel    (div_sel),
        .restart    (restart)
    );
endmodule

// File: tb/jitter_bit_collector_bench.sv
// Bench: behavioural per-cycle model compared against every output.
module jitter_bit_collector_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        ref_clk = 1'b0;
    logic        bit_out, bit_valid, word_valid;
    logic [15:0] word_out;
    logic [7:0]  freq_ctrl;
    logic [1:0]  div_sel;

    int vectors = 0;
    int fails   = 0;
    bit running = 1'b0;

    // Model state
    int ref_hist[$];
    int m_cnt, m_phase, m_armed, m_votes, m_ones, m_word, m_nbits, m_fcw, m_dsel;
    int m_bv, m_wv, m_words_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    jitter_bit_collector #(.DIV_SEL_RST(2'd1)) u_jitter_bit_collector (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .ref_clk_async (ref_clk),
        .bit_out       (bit_out),
        .bit_valid     (bit_valid),
        .word_out      (word_out),
        .word_valid    (word_valid),
        .freq_ctrl     (freq_ctrl),
        .div_sel       (div_sel)
    );

    task automatic model_reset();
        ref_hist = '{0, 0, 0, 0};
        m_cnt = 0; m_phase = 0; m_armed = 0; m_votes = 0; m_ones = 0;
        m_word = 0; m_nbits = 0; m_fcw = 0; m_dsel = 1; m_bv = 0; m_wv = 0;
    endtask

    // Reference model, advanced once per rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int ev, hit, tick, samp, lsb, done, nb, flip;
            ref_hist.push_front(int'(ref_clk));
            ref_hist = ref_hist[0:3];
            // R1: edge seen two flops late, against a third delayed copy
            ev   = (enable && ref_hist[2] == 1 && ref_hist[3] == 0) ? 1 : 0;
            // R2: one tick per 2^dsel edges
            hit  = (m_phase == (1 << m_dsel) - 1) ? 1 : 0;
            tick = ev & hit;
            // R3: only an armed measurement yields a sample
            samp = tick & m_armed;
            lsb  = m_cnt % 2;
            done = (samp && m_votes == 4) ? 1 : 0;
            // R4: majority of five
            nb   = (m_ones + lsb >= 3) ? 1 : 0;
            flip = (m_word & 1) ^ ((m_word >> 1) & 1);
            if (enable) m_cnt = tick ? 1 : (m_cnt + 1) % 65536;
            if (ev) m_phase = hit ? 0 : m_phase + 1;
            if (done && flip) m_armed = 0;
            else if (tick) m_armed = 1;
            if (samp) begin
                if (done) begin m_votes = 0; m_ones = 0; end
                else begin m_votes++; m_ones += lsb; end
            end
            m_bv = done;
            m_wv = 0;
            if (done) begin
                m_word = ((m_word << 1) | nb) & 16'hFFFF;
                m_nbits++;
                if (m_nbits % 16 == 0) begin m_wv = 1; m_words_done++; end
                m_fcw = (m_fcw + 5) % 256;
                if (flip) begin m_dsel = m_dsel ^ 1; m_phase = 0; end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            check("R1 R2 R3 R4 R5 bit_out", int'(bit_out), m_word & 1);
            check("R5 R9 bit_valid", int'(bit_valid), (m_bv != 0 && enable) ? 1 : 0);
            check("R6 word_out", int'(word_out), m_word);
            check("R6 R9 word_valid", int'(word_valid), (m_wv != 0 && enable) ? 1 : 0);
            check("R7 freq_ctrl", int'(freq_ctrl), m_fcw);
            check("R8 div_sel", int'(div_sel), m_dsel);
        end
    end

    // Reference generator with random half-periods.
    initial begin
        void'($urandom(32'h5eed_1234));
        forever begin
            repeat ($urandom_range(10, 2)) @(posedge clk);
            #1 ref_clk = ~ref_clk;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        m_words_done = 0;
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        // R10: reset values
        check("R10 word_out", int'(word_out), 0);
        check("R10 freq_ctrl", int'(freq_ctrl), 0);
        check("R10 div_sel", int'(div_sel), 1);
        check("R10 strobes", int'(bit_valid) + int'(word_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        enable = 1'b1;
        running = 1'b1;
        repeat (20000) @(posedge clk);
        #1;
        for (int k = 0; k < 30; k++) begin
            enable = 1'b0;                     // R9 pause windows
            repeat ($urandom_range(40, 5)) @(posedge clk);
            #1 enable = 1'b1;
            repeat ($urandom_range(600, 200)) @(posedge clk);
            #1;
        end
        @(negedge clk);
        running = 1'b0;
        // R7: wrap reached; R6: several words completed
        check("R7 wrap reached", (m_nbits >= 52) ? 1 : 0, 1);
        check("R6 words completed", (m_words_done >= 2) ? 1 : 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule